// File: doc/BRIEF.md
# Byte-Order Conversion Unit

This unit executes the byte-order conversion operation of a 64-bit register machine. It takes the current contents of a destination register, a direction bit, an operation-class bit and a 32-bit immediate that names the operating width. It returns the converted register value one clock cycle later. The byte order of the host is fixed when the unit is built, through a parameter.

In the 32-bit class, the direction bit names a target byte order, either little-endian or big-endian. The unit reverses bytes only when the target order differs from the host order. Otherwise it passes the low bits at the chosen width through unchanged. In the 64-bit class, direction code 0 always reverses the bytes at the chosen width, whatever the host order, and direction code 1 is reserved. Widths of 16 and 32 bits give a zero-extended result. An unknown width, or the reserved code, gives a zero result and raises an illegal flag.

The unit has registered outputs and a synchronous active-high reset. It is meant to sit in the execute stage beside the other arithmetic units. Register file access and instruction fetch belong to the surrounding pipeline.

Top module: `byteorder_conv`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, out_illegal and out_data are all zero.
- R2: out_valid equals in_valid as sampled at the previous rising clock edge (one cycle of latency).
- R3: The width is legal only when imm is exactly 16, 32 or 64 (decimal). Any other imm gives out_illegal = 1 and out_data = 0.
- R4: With cls64 = 0 and dir_be = 0 (target little-endian), a little-endian host passes the low imm bits through, and a big-endian host byte-reverses them.
- R5: With cls64 = 0 and dir_be = 1 (target big-endian), a big-endian host passes the low imm bits through, and a little-endian host byte-reverses them.
- R6: With cls64 = 1 and dir_be = 0, the low imm/8 bytes are always reversed for either host order. Byte k of the result (byte 0 = bits 7:0) is byte imm/8-1-k of in_data.
- R7: With cls64 = 1 and dir_be = 1 (reserved), out_illegal = 1 and out_data = 0.
- R8: For a legal width of 16 or 32, the result bits at and above that width are zero in every mode.
- R9: A legal request gives out_illegal = 0. While in_valid is low, out_data and out_illegal keep their previous values.
- R10: The parameter HOST_BIG_ENDIAN (0 = little-endian host, 1 = big-endian host) selects the host order, and both settings follow R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Destination register value |
| dir_be | input | 1 | Direction: 0 = to little-endian / reverse, 1 = to big-endian |
| cls64 | input | 1 | Operation class: 0 = 32-bit class, 1 = 64-bit class |
| imm | input | 32 | Operating width in bits (16, 32 or 64) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 64 | Converted value |
| out_illegal | output | 1 | Illegal width or reserved class/direction code |

## Verification
The assertions check on every cycle that the valid strobe has one cycle of latency. They also check that illegal widths and the reserved 64-bit code give a flagged zero result, that legal requests are not flagged, that narrow widths leave the upper bits clear, and that idle cycles keep the outputs. The actual byte permutation, and how it depends on the host order, can only be shown by the bench scenarios. The bench sweeps every class, direction and width code on both host-order builds and compares each result with byte reversals it computes itself.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_BAD = 2'd3
  } size_e;

  localparam int N_SIZES = 3;
endpackage

// File: rtl/bo_size_decode.sv
module bo_size_decode
  import bo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm,
  output size_e            size
);
  always_comb begin
    if (imm == IMM_W'(16))      size = SZ_16;
    else if (imm == IMM_W'(32)) size = SZ_32;
    else if (imm == IMM_W'(64)) size = SZ_64;
    else                        size = SZ_BAD;
  end
endmodule

// File: rtl/bo_lane_reverse.sv
module bo_lane_reverse #(
  parameter int NBYTES = 2,
  parameter int DATA_W = 64
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [DATA_W-1:0]   rev,
  output logic [DATA_W-1:0]   trunc
);
  localparam int LANE_W = 8 * NBYTES;

  logic [LANE_W-1:0] swapped;

  // byte k of the output takes byte NBYTES-1-k of the input
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign swapped[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
  end

  if (LANE_W < DATA_W) begin : g_pad
    assign rev   = {{(DATA_W-LANE_W){1'b0}}, swapped};
    assign trunc = {{(DATA_W-LANE_W){1'b0}}, din};
  end else begin : g_full
    assign rev   = swapped;
    assign trunc = din;
  end
endmodule

// File: rtl/bo_result_mux.sv
module bo_result_mux
  import bo_pkg::*;
#(
  parameter int DATA_W          = 64,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  size_e             size,
  input  logic              dir_be,
  input  logic              cls64,
  input  logic [DATA_W-1:0] rev   [N_SIZES],
  input  logic [DATA_W-1:0] trunc [N_SIZES],
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic swap;

  always_comb begin
    // wide class always swaps; narrow class swaps only when orders differ
    swap    = cls64 | (dir_be != HOST_BIG_ENDIAN);
    illegal = (size == SZ_BAD) | (cls64 & dir_be);
    result  = '0;
    if (!illegal) begin
      unique case (size)
        SZ_16:   result = swap ? rev[0] : trunc[0];
        SZ_32:   result = swap ? rev[1] : trunc[1];
        SZ_64:   result = swap ? rev[2] : trunc[2];
        default: result = '0;
      endcase
    end
  end
endmodule

// File: rtl/byteorder_conv.sv
module byteorder_conv
  import bo_pkg::*;
#(
  parameter int DATA_W          = 64,
  parameter int IMM_W           = 32,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              dir_be,
  input  logic              cls64,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  size_e             size;
  logic [DATA_W-1:0] rev_w   [N_SIZES];
  logic [DATA_W-1:0] trunc_w [N_SIZES];
  logic [DATA_W-1:0] result;
  logic              illegal;

  bo_size_decode #(.IMM_W(IMM_W)) u_dec (
    .imm  (imm),
    .size (size)
  );

  // one reverser per legal width: 2, 4 and 8 bytes
  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int NB = 2 << s;
    bo_lane_reverse #(.NBYTES(NB), .DATA_W(DATA_W)) u_rev (
      .din   (in_data[8*NB-1:0]),
      .rev   (rev_w[s]),
      .trunc (trunc_w[s])
    );
  end

  bo_result_mux #(.DATA_W(DATA_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_mux (
    .size    (size),
    .dir_be  (dir_be),
    .cls64   (cls64),
    .rev     (rev_w),
    .trunc   (trunc_w),
    .result  (result),
    .illegal (illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= result;
        out_illegal <= illegal;
      end
    end
  end
endmodule

// File: rtl/bo_conv_chk.sv
module bo_conv_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              dir_be,
  input logic              cls64,
  input logic [IMM_W-1:0]  imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);
  logic w16, w32, w64, legal;
  assign w16   = (imm == IMM_W'(16));
  assign w32   = (imm == IMM_W'(32));
  assign w64   = (imm == IMM_W'(64));
  assign legal = w16 | w32 | w64;

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3
  bad_width_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (out_illegal && out_data == '0));
  // R7
  reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls64 && dir_be) |=> (out_illegal && out_data == '0));
  // R9
  legal_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && !(cls64 && dir_be)) |=> !out_illegal);
  // R8
  upper16_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && w16) |=> (out_data[DATA_W-1:16] == '0));
  // R8
  upper32_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && w32) |=> (out_data[DATA_W-1:32] == '0));
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));
endmodule

bind byteorder_conv bo_conv_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .dir_be      (dir_be),
  .cls64       (cls64),
  .imm         (imm),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/byteorder_conv_bench.sv
`timescale 1ns/1ps
module byteorder_conv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        dir_be = 1'b0;
  logic        cls64 = 1'b0;
  logic [31:0] imm = '0;

  logic        v_le, il_le, v_be, il_be;
  logic [63:0] d_le, d_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  byteorder_conv #(.HOST_BIG_ENDIAN(1'b0)) u_byteorder_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .dir_be(dir_be), .cls64(cls64), .imm(imm),
    .out_valid(v_le), .out_data(d_le), .out_illegal(il_le));

  byteorder_conv #(.HOST_BIG_ENDIAN(1'b1)) u_byteorder_conv_be (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .dir_be(dir_be), .cls64(cls64), .imm(imm),
    .out_valid(v_be), .out_data(d_be), .out_illegal(il_be));

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic logic [63:0] model(bit host_be, logic [63:0] v, bit dir,
                                        bit cls, logic [31:0] w, output bit ill);
    logic [63:0] r;
    int nb;
    bit swap;
    ill = !(w == 16 || w == 32 || w == 64) || (cls && dir);
    if (ill) return 64'd0;
    nb   = int'(w) / 8;
    swap = cls ? 1'b1 : (dir != host_be);
    r    = '0;
    for (int k = 0; k < nb; k++) begin
      if (swap) r = r | (((v >> (8*(nb-1-k))) & 64'hFF) << (8*k));
      else      r = r | (v & (64'hFF << (8*k)));
    end
    return r;
  endfunction

  function automatic string tag(bit host_be, bit dir, bit cls, logic [31:0] w);
    if (!(w == 16 || w == 32 || w == 64)) return "R3";
    if (cls && dir) return "R7";
    if (cls) return "R6";
    if (dir) return host_be ? "R5/R10 big host" : "R5/R10 little host";
    return host_be ? "R4/R10 big host" : "R4/R10 little host";
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [4];
    logic [31:0] imms [8];
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFFEE_DDCC_BBAA_9988;
    pats[2] = 64'h8000_0000_0000_0001;
    pats[3] = 64'h1122_3344_5566_7788;
    imms[0] = 32'd16; imms[1] = 32'd32; imms[2] = 32'd64; imms[3] = 32'd0;
    imms[4] = 32'd8;  imms[5] = 32'd48; imms[6] = 32'd65; imms[7] = 32'hFFFF_FFF0;

    repeat (3) @(negedge clk);
    // R1 during reset
    check64("R1 valid", {63'd0, v_le}, 64'd0);
    check64("R1 data", d_be, 64'd0);
    in_valid = 1'b1; in_data = pats[0]; imm = 32'd16;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    // R1 first cycle after reset (no request was accepted)
    check64("R1 valid after reset", {62'd0, v_le, v_be}, 64'd0);
    check64("R1 data after reset", d_le, 64'd0);
    check64("R1 illegal after reset", {62'd0, il_le, il_be}, 64'd0);

    foreach (pats[p]) begin
      for (int c = 0; c < 2; c++) begin
        for (int d = 0; d < 2; d++) begin
          foreach (imms[w]) begin
            bit ill0, ill1;
            logic [63:0] e0, e1;
            in_valid = 1'b1; in_data = pats[p]; cls64 = c[0]; dir_be = d[0];
            imm = imms[w];
            e0 = model(1'b0, pats[p], d[0], c[0], imms[w], ill0);
            e1 = model(1'b1, pats[p], d[0], c[0], imms[w], ill1);
            @(negedge clk);
            check64("R2 valid", {62'd0, v_le, v_be}, 64'd3);
            check64(tag(1'b0, d[0], c[0], imms[w]), d_le, e0);
            check64(tag(1'b1, d[0], c[0], imms[w]), d_be, e1);
            check64("R3/R7/R9 illegal flag", {62'd0, il_le, il_be}, {62'd0, ill0, ill1});
            if (!ill0 && imms[w] != 32'd64) begin
              // R8 upper bits clear at narrow widths
              check64("R8 upper bits", d_le >> imms[w], 64'd0);
              check64("R8 upper bits", d_be >> imms[w], 64'd0);
            end
            if (w == 1) begin
              // R9 hold while idle: new inputs must not reach the outputs
              in_valid = 1'b0; in_data = ~pats[p]; imm = 32'd5;
              @(negedge clk);
              check64("R2 idle valid", {62'd0, v_le, v_be}, 64'd0);
              check64("R9 hold data", d_le, e0);
              check64("R9 hold data", d_be, e1);
              check64("R9 hold flag", {62'd0, il_le, il_be}, {62'd0, ill0, ill1});
            end
          end
        end
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule